// File: doc/BRIEF.md
# BPSK Sine-Table Modulator

This block produces a binary phase shift keyed carrier as a stream of 12-bit samples for a serial DAC writer. One carrier period is stored as a small table of signed fixed-point sine values. A pointer steps through the table at a fixed rate. Each sample is either the table value or its negation, chosen by the current data bit, so that a change of bit flips the carrier phase by 180 degrees. A constant of half the DAC range is added so that the unsigned converter sees a waveform centred on mid-scale.

The block also paces the rest of the transmitter. A single prescale counter gives three timing outputs. The first is a one-cycle strobe for each carrier step. The second is a periodic enable for the serial link to the DAC. The third is a data clock that rises at the start of each carrier period, which is when a new data bit has just been taken. A data source clocked on the rising edge of that clock therefore has a whole carrier period to settle its next bit. For waveform inspection, a parameter can bypass the mid-scale offset so that the signed sample appears directly.

Top module: `bpsk_sine_mod`

## Requirements
- R1: While reset is high, and in the first cycle after it, the sample is mid-scale (2048), or 0 when the signed mode is selected. In the same cycles the step strobe and the link enable are low, the data clock is low, the table pointer is at its last entry (31) and the held data bit is 1.
- R2: The step strobe is high for exactly one cycle in every STEP_DIV clock cycles. Counting from the first cycle after reset as cycle 0, it is high in cycle STEP_DIV-1.
- R3: The link enable is high for exactly one cycle in every SPI_DIV clock cycles. Counting from the first cycle after reset as cycle 0, it is high in cycle SPI_DIV-1.
- R4: The data clock is high while the table pointer lies in the first half of the table (entries 0 to 15) and low otherwise. It rises only in the cycle after the pointer wraps to entry 0.
- R5: On each step strobe the table pointer moves up by one entry, and from entry 31 it moves to entry 0. The pointer holds its value in every other cycle. The sample register loads the value selected by the pointer and the data bit as they stood in the previous cycle.
- R6: Entry i of the table is 2·sin(2π·i/32). It is scaled by 2^10, truncated toward zero, clamped to +2047 and given its original sign as a 12-bit two's-complement word, so entries 8 and 24 hold +2047 and −2047.
- R7: When the held data bit is 1 the sample carries the table entry unchanged. When the held data bit is 0 the sample carries the two's-complement negation of the entry.
- R8: The serial data input is taken only in the cycle in which the step strobe is high and the pointer is at entry 31. A change on that input at any other time leaves the samples unchanged.
- R9: With the offset enabled (SIGNED_OUT = 0), the sample equals the signed value plus 2048, modulo 4096. It therefore ranges from 1 to 4095 and is never 0.
- R10: With SIGNED_OUT = 1, the sample is the signed value itself as a 12-bit two's-complement word, with no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_bit | input | 1 | Serial data bit, taken once per carrier period |
| sample_out | output | 12 | Carrier sample word for the DAC writer |
| data_clk | output | 1 | Bit-rate clock for the data source, rising at each carrier period start |
| spi_ce | output | 1 | One-cycle enable that paces the serial DAC link |
| step_stb | output | 1 | One-cycle strobe for each carrier table step |

## Verification
The assertions assume that reset is held for at least one clock edge before any check, and that STEP_DIV and SPI_DIV are powers of two no smaller than 2. Under that assumption the strobes can never be high in two cycles in a row. The serial input may change in any cycle, because the design reads it only at the pointer wrap. The stimulus exploits this by changing the bit every cycle in one phase and holding it constant for long runs in the others. A mid-run reset is applied once, so that recovery to the reset state is exercised as well as start-up.

// File: rtl/bpsk_pkg.sv
package bpsk_pkg;

    typedef enum logic {
        PHASE_INV  = 1'b0,
        PHASE_KEEP = 1'b1
    } polarity_e;

    localparam real TWO_PI = 6.283185307179586;

    // Series sine, valid on [0, pi/2]; enough terms for far below one LSB.
    function automatic real series_sin(input real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int n = 1; n < 12; n++) begin
            term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Fixed-point code of 2*sin(2*pi*idx/depth), truncated toward zero.
    function automatic int sine_code(input int idx, input int depth,
                                     input int width, input int frac);
        int  half;
        int  quarter;
        int  fold;
        int  code;
        int  limit;
        bit  negative;
        real mag;
        half     = depth / 2;
        quarter  = depth / 4;
        negative = (idx >= half);
        fold     = idx % half;
        if (fold > quarter) fold = half - fold;
        mag   = 2.0 * series_sin(TWO_PI * real'(fold) / real'(depth))
                * real'(1 << frac);
        code  = $rtoi(mag);
        limit = (1 << (width - 1)) - 1;
        if (code > limit) code = limit;
        return negative ? -code : code;
    endfunction

endpackage

// File: rtl/bpsk_prescaler.sv
module bpsk_prescaler #(
    parameter int STEP_DIV = 64,
    parameter int SPI_DIV  = 2,
    parameter int DEPTH    = 32
) (
    input  logic clk,
    input  logic rst,
    output logic step_stb,
    output logic spi_ce
);
    localparam int PRE_N  = STEP_DIV * DEPTH;
    localparam int PRE_W  = $clog2(PRE_N);
    localparam int STEP_W = $clog2(STEP_DIV);
    localparam int SPI_W  = $clog2(SPI_DIV);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == PRE_W'(PRE_N - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign step_stb = (cnt_q[STEP_W-1:0] == STEP_W'(STEP_DIV - 1));
    assign spi_ce   = (cnt_q[SPI_W-1:0]  == SPI_W'(SPI_DIV - 1));

endmodule

// File: rtl/bpsk_phase_ctrl.sv
module bpsk_phase_ctrl
    import bpsk_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_stb,
    input  logic             serial_bit,
    output logic [PTR_W-1:0] ptr_q,
    output polarity_e        pol_q,
    output logic             data_clk
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] HALF = PTR_W'(DEPTH / 2);

    logic wrap;
    assign wrap = step_stb && (ptr_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= LAST;
        end else if (step_stb) begin
            ptr_q <= wrap ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= PHASE_KEEP;
        end else if (wrap) begin
            pol_q <= polarity_e'(serial_bit);
        end
    end

    assign data_clk = (ptr_q < HALF);

endmodule

// File: rtl/bpsk_sample_gen.sv
module bpsk_sample_gen
    import bpsk_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int PTR_W      = 5,
    parameter int SAMPLE_W   = 12,
    parameter int FRAC_W     = 10,
    parameter int SIGNED_OUT = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PTR_W-1:0]    ptr,
    input  polarity_e           pol,
    output logic [SAMPLE_W-1:0] sample_q
);
    localparam logic [SAMPLE_W-1:0] MID     = {1'b1, {(SAMPLE_W-1){1'b0}}};
    localparam logic [SAMPLE_W-1:0] RST_VAL = (SIGNED_OUT != 0) ? {SAMPLE_W{1'b0}} : MID;

    logic [SAMPLE_W-1:0] table_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : gen_table
        localparam int CODE = sine_code(g, DEPTH, SAMPLE_W, FRAC_W);
        assign table_q[g] = SAMPLE_W'(CODE);
    end

    logic [SAMPLE_W-1:0] entry;
    logic [SAMPLE_W-1:0] chosen;
    logic [SAMPLE_W-1:0] shaped;

    assign entry  = table_q[ptr];
    assign chosen = (pol == PHASE_KEEP) ? entry : (~entry + 1'b1);

    if (SIGNED_OUT != 0) begin : gen_raw
        assign shaped = chosen;
    end else begin : gen_offset
        assign shaped = chosen + MID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= RST_VAL;
        end else begin
            sample_q <= shaped;
        end
    end

endmodule

// File: rtl/bpsk_sine_mod.sv
module bpsk_sine_mod
    import bpsk_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int SAMPLE_W   = 12,
    parameter int FRAC_W     = 10,
    parameter int STEP_DIV   = 64,
    parameter int SPI_DIV    = 2,
    parameter int SIGNED_OUT = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                serial_bit,
    output logic [SAMPLE_W-1:0] sample_out,
    output logic                data_clk,
    output logic                spi_ce,
    output logic                step_stb
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0] ptr_q;
    polarity_e        pol_q;
    logic             pol_bit;

    assign pol_bit = (pol_q == PHASE_KEEP);

    bpsk_prescaler #(
        .STEP_DIV (STEP_DIV),
        .SPI_DIV  (SPI_DIV),
        .DEPTH    (DEPTH)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .step_stb (step_stb),
        .spi_ce   (spi_ce)
    );

    bpsk_phase_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) u_phase (
        .clk        (clk),
        .rst        (rst),
        .step_stb   (step_stb),
        .serial_bit (serial_bit),
        .ptr_q      (ptr_q),
        .pol_q      (pol_q),
        .data_clk   (data_clk)
    );

    bpsk_sample_gen #(
        .DEPTH      (DEPTH),
        .PTR_W      (PTR_W),
        .SAMPLE_W   (SAMPLE_W),
        .FRAC_W     (FRAC_W),
        .SIGNED_OUT (SIGNED_OUT)
    ) u_samp (
        .clk      (clk),
        .rst      (rst),
        .ptr      (ptr_q),
        .pol      (pol_q),
        .sample_q (sample_out)
    );

endmodule

// File: rtl/bpsk_sine_mod_chk.sv
module bpsk_sine_mod_chk #(
    parameter int DEPTH      = 32,
    parameter int PTR_W      = 5,
    parameter int SAMPLE_W   = 12,
    parameter int SIGNED_OUT = 0
) (
    input logic                clk,
    input logic                rst,
    input logic                step_stb,
    input logic                spi_ce,
    input logic                data_clk,
    input logic [SAMPLE_W-1:0] sample_out,
    input logic [PTR_W-1:0]    ptr,
    input logic                pol
);
    localparam logic [PTR_W-1:0]    LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0]    HALF = PTR_W'(DEPTH / 2);
    localparam logic [SAMPLE_W-1:0] MID  = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [SAMPLE_W-1:0] as_signed;
    assign as_signed = (SIGNED_OUT != 0) ? sample_out : (sample_out ^ MID);

    logic pos_half;
    assign pos_half = (ptr != '0) && (ptr < HALF);

    assert_stb_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        step_stb |=> !step_stb);

    assert_ce_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        spi_ce |=> !spi_ce);

    assert_dclk_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(data_clk) |-> (ptr == '0));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (step_stb && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));

    assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (step_stb && ptr == LAST) |=> (ptr == '0));

    assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !step_stb |=> $stable(ptr));

    assert_keep_sign_R7: assert property (@(posedge clk) disable iff (rst)
        (pos_half && pol) |=> (as_signed > 0));

    assert_flip_sign_R7: assert property (@(posedge clk) disable iff (rst)
        (pos_half && !pol) |=> (as_signed < 0));

    assert_pol_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(step_stb && ptr == LAST) |=> $stable(pol));

    if (SIGNED_OUT == 0) begin : gen_offset_chk
        assert_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
            sample_out != '0);
    end

endmodule

bind bpsk_sine_mod bpsk_sine_mod_chk #(
    .DEPTH      (DEPTH),
    .PTR_W      (PTR_W),
    .SAMPLE_W   (SAMPLE_W),
    .SIGNED_OUT (SIGNED_OUT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .step_stb   (step_stb),
    .spi_ce     (spi_ce),
    .data_clk   (data_clk),
    .sample_out (sample_out),
    .ptr        (ptr_q),
    .pol        (pol_bit)
);

// File: tb/sim_bpsk_sine_mod.sv
module sim_bpsk_sine_mod;
    localparam int D = 32;
    localparam int W = 12;
    localparam int F = 10;
    localparam int S = 4;
    localparam int P = 2;
    localparam int MASK = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sbit = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] s0, s1;
    logic dclk0, ce0, stb0, dclk1, ce1, stb1;

    bpsk_sine_mod #(.DEPTH(D), .SAMPLE_W(W), .FRAC_W(F), .STEP_DIV(S),
                    .SPI_DIV(P), .SIGNED_OUT(0)) u0 (
        .clk(clk), .rst(rst), .serial_bit(sbit), .sample_out(s0),
        .data_clk(dclk0), .spi_ce(ce0), .step_stb(stb0));

    bpsk_sine_mod #(.DEPTH(D), .SAMPLE_W(W), .FRAC_W(F), .STEP_DIV(S),
                    .SPI_DIV(P), .SIGNED_OUT(1)) u1 (
        .clk(clk), .rst(rst), .serial_bit(sbit), .sample_out(s1),
        .data_clk(dclk1), .spi_ce(ce1), .step_stb(stb1));

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string samp_tag = "R5 R7";

    // Reference model state
    int m_cnt = 0, m_ptr = D - 1, m_bit = 1, m_s0 = 2048, m_s1 = 0;
    int max_s0 = 0, min_s0 = MASK;

    function automatic int ref_entry(input int i);
        real a;
        int  m;
        a = 2.0 * $sin(6.283185307179586 * real'(i) / real'(D));
        m = $rtoi(((a < 0.0) ? -a : a) * real'(1 << F));
        if (m > (1 << (W - 1)) - 1) m = (1 << (W - 1)) - 1;
        return (a < 0.0) ? -m : m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_ptr = D - 1; m_bit = 1; m_s0 = 2048; m_s1 = 0;
        end else begin
            int v;
            v = m_bit ? ref_entry(m_ptr) : -ref_entry(m_ptr);
            m_s0 = (v + 2048) & MASK;
            m_s1 = v & MASK;
            if (m_cnt % S == S - 1) begin
                if (m_ptr == D - 1) begin
                    m_ptr = 0;
                    m_bit = sbit;
                end else begin
                    m_ptr++;
                end
            end
            m_cnt = (m_cnt + 1) % (S * D);
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            check(stb0 == (m_cnt % S == S - 1), "R2 step_stb", stb0, m_cnt % S == S - 1);
            check(ce0 == (m_cnt % P == P - 1), "R3 spi_ce", ce0, m_cnt % P == P - 1);
            check(dclk0 == (m_ptr < D / 2), "R4 data_clk", dclk0, m_ptr < D / 2);
            check(int'(s0) == m_s0, {samp_tag, " R9 sample"}, s0, m_s0);
            check(int'(s1) == m_s1, "R10 signed sample", s1, m_s1);
            if (!rst) begin
                if (s0 > max_s0) max_s0 = s0;
                if (s0 < min_s0) min_s0 = s0;
            end
        end
    end

    task automatic run(input int cycles, input int mode);
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            case (mode)
                0: sbit = 1'b1;
                1: sbit = 1'b0;
                2: sbit = ((c / (S * D)) % 2) == 0;
                default: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    sbit = lfsr[0];
                end
            endcase
        end
    endtask

    task automatic reset_check;
        check(s0 == 12'd2048, "R1 sample mid-scale", s0, 2048);
        check(s1 == 12'd0, "R1 signed sample zero", s1, 0);
        check(stb0 == 1'b0, "R1 step_stb low", stb0, 0);
        check(ce0 == 1'b0, "R1 spi_ce low", ce0, 0);
        check(dclk0 == 1'b0, "R1 data_clk low", dclk0, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        reset_check();
        rst = 1'b0;
        samp_tag = "R5 R7 const-one";
        run(3 * S * D, 0);
        samp_tag = "R7 const-zero";
        run(3 * S * D, 1);
        samp_tag = "R7 alternating";
        run(4 * S * D, 2);
        samp_tag = "R8 toggling";
        run(6 * S * D, 3);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        reset_check();
        rst = 1'b0;
        samp_tag = "R5 R8 after reset";
        run(4 * S * D, 3);
        run(2 * S * D, 0);
        @(negedge clk);
        finished = 1;
        check(max_s0 == 4095, "R6 peak +2047 with offset", max_s0, 4095);
        check(min_s0 == 1, "R6 trough -2047 with offset", min_s0, 1);
        check(ref_entry(4) == 1448, "R6 entry 4 truncation", ref_entry(4), 1448);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule